// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node directory of a distributed shared-memory machine. For each memory block it owns, it records a coherence state (Uncached, Shared or Exclusive) and a presence vector with one bit per processor. It also keeps the block's data in a small internal store. Caches send it read-miss and write-miss requests tagged with their processor number and the block address. The directory answers by sending point-to-point messages only to the caches concerned: invalidations, fetches, fetch-with-invalidate, and finally a data reply to the requester. No bus is involved.

Remote caches return dirty data as write-back messages. A write-back either answers a fetch or is an eviction by the current owner. Requests are serviced strictly one at a time. While the directory waits for an owner's write-back, it holds its request port not ready. The message ports use a valid/ready handshake and assume in-order delivery.

Top module: `dir_home`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector and zero data, `req_ready` is high and `msg_valid` is low.
- R2: A read miss (`req_write`=0) to an Uncached block produces one data reply (`msg_kind`=3) to the requester carrying the stored data, and leaves the block Shared with only the requester present.
- R3: A read miss to a Shared block adds the requester to the presence vector and produces only a data reply; the block stays Shared.
- R4: A write miss (`req_write`=1) to an Uncached block produces only a data reply and makes the requester the single Exclusive owner.
- R5: A write miss to a Shared block first sends one invalidation (`msg_kind`=0) per cycle to every present processor other than the requester, in ascending processor number, then a data reply; the requester becomes the single Exclusive owner.
- R6: A read miss to an Exclusive block sends a fetch (`msg_kind`=1) to the owner, waits for its write-back, stores that data, replies it to the requester, and leaves the block Shared with owner and requester present.
- R7: A write miss to an Exclusive block sends a fetch-with-invalidate (`msg_kind`=2) to the owner, stores the written-back data, replies it to the requester, and leaves the requester as the single Exclusive owner.
- R8: A write-back accepted while idle from the owner of an Exclusive block stores its data, empties the presence vector and makes the block Uncached.
- R9: A write-back accepted while idle for a block that the sender does not hold Exclusive is ignored: data, state and presence vector are unchanged.
- R10: Once a request is accepted, `req_ready` stays low until its data reply is handed off; when a write-back and a request arrive together while idle, the write-back is taken first.
- R11: While `msg_valid` is high and `msg_ready` is low, the outgoing message holds valid and keeps its kind, destination and data unchanged.
- R12: An Exclusive block always has exactly one bit set in its presence vector, and an Uncached block has none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Directory accepts a request this cycle |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_pid | input | PW | Requesting processor number |
| req_addr | input | AW | Block address of the request |
| wb_valid | input | 1 | Write-back message present |
| wb_ready | output | 1 | Directory accepts a write-back this cycle |
| wb_pid | input | PW | Processor sending the write-back |
| wb_addr | input | AW | Block address of the write-back |
| wb_data | input | DW | Written-back block data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the outgoing message |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-invalidate, 3 data reply |
| msg_pid | output | PW | Destination processor |
| msg_addr | output | AW | Block address of the message |
| msg_data | output | DW | Reply data (zero for other kinds) |

## Verification
The bench builds the block with four processors, eight blocks and 16-bit data. Four processors are enough for a write miss to find several sharers, including the requester itself, so both the ascending order of invalidations and the requester's exclusion are visible. Eight blocks let independent scenarios run on separate addresses: the eviction and stale write-back cases, and a write-back that meets a simultaneous request. Every transition of all three states is driven, and the resulting state is read back through the order and content of the following messages.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {
      BLK_UNC = 2'd0,
      BLK_SHR = 2'd1,
      BLK_EXC = 2'd2
   } blk_st_t;

   typedef enum logic [1:0] {
      MK_INV      = 2'd0,
      MK_FETCH    = 2'd1,
      MK_FETCHINV = 2'd2,
      MK_DATA     = 2'd3
   } msg_kind_t;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_INV   = 3'd1,
      S_FETCH = 3'd2,
      S_WAIT  = 3'd3,
      S_REPLY = 3'd4
   } fsm_t;
endpackage

// File: rtl/dir_pick.sv
module dir_pick #(
   parameter int N = 4,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] idx,
   output logic         any
);
   if (N < 2) begin : g_bad_n
      $error("dir_pick: N must be at least 2");
   end

   always_comb begin
      idx = '0;
      any = |vec;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = W'(i);
      end
   end
endmodule

// File: rtl/dir_table.sv
module dir_table
   import dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int NBLK  = 8,
   parameter int DW    = 16,
   localparam int AW   = $clog2(NBLK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   output blk_st_t          rd_st,
   output logic [NPROC-1:0] rd_shr,
   output logic [DW-1:0]    rd_data,
   input  logic             wr_en,
   input  blk_st_t          wr_st,
   input  logic [NPROC-1:0] wr_shr,
   input  logic             mw_en,
   input  logic [DW-1:0]    mw_data
);
   if (NBLK < 2 || (1 << AW) != NBLK) begin : g_bad_blk
      $error("dir_table: NBLK must be a power of two, at least 2");
   end

   blk_st_t          st_q  [NBLK];
   logic [NPROC-1:0] shr_q [NBLK];
   logic [DW-1:0]    mem_q [NBLK];

   assign rd_st   = st_q[addr];
   assign rd_shr  = shr_q[addr];
   assign rd_data = mem_q[addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NBLK; b++) begin
            st_q[b]  <= BLK_UNC;
            shr_q[b] <= '0;
            mem_q[b] <= '0;
         end
      end else begin
         if (wr_en) begin
            st_q[addr]  <= wr_st;
            shr_q[addr] <= wr_shr;
         end
         if (mw_en) mem_q[addr] <= mw_data;
      end
   end

   // R12: presence vector agrees with the state being written
   assert_exc_one_owner_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_st == BLK_EXC) |-> ($countones(wr_shr) == 1));
   assert_unc_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_st == BLK_UNC) |-> (wr_shr == '0));
endmodule

// File: rtl/dir_home.sv
module dir_home
   import dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int NBLK  = 8,
   parameter int DW    = 16,
   localparam int PW   = $clog2(NPROC),
   localparam int AW   = $clog2(NBLK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [PW-1:0] req_pid,
   input  logic [AW-1:0] req_addr,
   input  logic          wb_valid,
   output logic          wb_ready,
   input  logic [PW-1:0] wb_pid,
   input  logic [AW-1:0] wb_addr,
   input  logic [DW-1:0] wb_data,
   output logic          msg_valid,
   input  logic          msg_ready,
   output logic [1:0]    msg_kind,
   output logic [PW-1:0] msg_pid,
   output logic [AW-1:0] msg_addr,
   output logic [DW-1:0] msg_data
);
   if (NPROC < 2 || (1 << PW) != NPROC) begin : g_bad_proc
      $error("dir_home: NPROC must be a power of two, at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dir_home: DW must be positive");
   end

   fsm_t             fsm;
   logic [PW-1:0]    cur_pid;
   logic [AW-1:0]    cur_addr;
   logic             cur_wr;
   logic [NPROC-1:0] pend;

   logic [AW-1:0]    t_addr;
   blk_st_t          t_st;
   logic [NPROC-1:0] t_shr;
   logic [DW-1:0]    t_data;
   logic             tw_en, mw_en;
   blk_st_t          tw_st;
   logic [NPROC-1:0] tw_shr;
   logic [DW-1:0]    mw_data;

   logic [NPROC-1:0] pick_in;
   logic [PW-1:0]    pick_idx;
   logic             pick_any;
   logic [NPROC-1:0] req_oh, cur_oh, pick_oh;
   logic             idle, wb_take, req_take;

   assign idle     = (fsm == S_IDLE);
   assign req_oh   = NPROC'(1) << req_pid;
   assign cur_oh   = NPROC'(1) << cur_pid;
   assign pick_oh  = NPROC'(1) << pick_idx;
   assign t_addr   = idle ? (wb_valid ? wb_addr : req_addr) : cur_addr;
   assign pick_in  = (fsm == S_INV) ? pend : t_shr;

   assign req_ready = idle && !wb_valid;
   assign wb_ready  = idle || (fsm == S_WAIT && wb_addr == cur_addr);
   assign wb_take   = wb_valid && wb_ready;
   assign req_take  = req_valid && req_ready;

   dir_table #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (t_addr),
      .rd_st   (t_st),
      .rd_shr  (t_shr),
      .rd_data (t_data),
      .wr_en   (tw_en),
      .wr_st   (tw_st),
      .wr_shr  (tw_shr),
      .mw_en   (mw_en),
      .mw_data (mw_data)
   );

   dir_pick #(.N(NPROC)) u_pick (
      .vec (pick_in),
      .idx (pick_idx),
      .any (pick_any)
   );

   // outgoing message
   always_comb begin
      msg_valid = 1'b0;
      msg_kind  = MK_INV;
      msg_pid   = pick_idx;
      msg_addr  = cur_addr;
      msg_data  = '0;
      case (fsm)
         S_INV:   begin msg_valid = 1'b1; msg_kind = MK_INV; end
         S_FETCH: begin
            msg_valid = 1'b1;
            msg_kind  = cur_wr ? MK_FETCHINV : MK_FETCH;
         end
         S_REPLY: begin
            msg_valid = 1'b1;
            msg_kind  = MK_DATA;
            msg_pid   = cur_pid;
            msg_data  = t_data;
         end
         default: ;
      endcase
   end

   // directory table update
   always_comb begin
      tw_en   = 1'b0;
      tw_st   = t_st;
      tw_shr  = t_shr;
      mw_en   = 1'b0;
      mw_data = wb_data;
      if (idle && wb_valid) begin
         if (t_st == BLK_EXC && t_shr[wb_pid]) begin
            tw_en  = 1'b1;
            tw_st  = BLK_UNC;
            tw_shr = '0;
            mw_en  = 1'b1;
         end
      end else if (req_take) begin
         case (t_st)
            BLK_UNC: begin
               tw_en  = 1'b1;
               tw_st  = req_write ? BLK_EXC : BLK_SHR;
               tw_shr = req_oh;
            end
            BLK_SHR: begin
               tw_en  = 1'b1;
               tw_st  = req_write ? BLK_EXC : BLK_SHR;
               tw_shr = req_write ? req_oh : (t_shr | req_oh);
            end
            default: ;
         endcase
      end else if (fsm == S_WAIT && wb_take) begin
         tw_en  = 1'b1;
         tw_st  = cur_wr ? BLK_EXC : BLK_SHR;
         tw_shr = cur_wr ? cur_oh : (t_shr | cur_oh);
         mw_en  = 1'b1;
      end
   end

   // control sequence
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm      <= S_IDLE;
         cur_pid  <= '0;
         cur_addr <= '0;
         cur_wr   <= 1'b0;
         pend     <= '0;
      end else begin
         case (fsm)
            S_IDLE: if (req_take) begin
               cur_pid  <= req_pid;
               cur_addr <= req_addr;
               cur_wr   <= req_write;
               case (t_st)
                  BLK_SHR: begin
                     pend <= t_shr & ~req_oh;
                     fsm  <= (req_write && |(t_shr & ~req_oh)) ? S_INV : S_REPLY;
                  end
                  BLK_EXC: fsm <= S_FETCH;
                  default: fsm <= S_REPLY;
               endcase
            end
            S_INV: if (msg_ready) begin
               pend <= pend & ~pick_oh;
               if ((pend & ~pick_oh) == '0) fsm <= S_REPLY;
            end
            S_FETCH: if (msg_ready) fsm <= S_WAIT;
            S_WAIT:  if (wb_take) fsm <= S_REPLY;
            S_REPLY: if (msg_ready) fsm <= S_IDLE;
            default: fsm <= S_IDLE;
         endcase
      end
   end

   // R10: a second request is never taken right after one is accepted
   assert_one_at_a_time_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_take |=> !req_ready);
   // R11: a stalled message does not change
   assert_msg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) &&
                                     $stable(msg_pid) && $stable(msg_data)));
   // R5: invalidations skip the requester
   assert_inv_not_requester_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_kind == MK_INV) |-> (msg_pid != cur_pid));
   // R5: successive invalidations go in ascending processor order
   assert_inv_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready && msg_kind == MK_INV) |=>
         (!(msg_valid && msg_kind == MK_INV) || (msg_pid > $past(msg_pid))));
   // R6: a write-back answering a fetch leads straight to the reply
   assert_wb_then_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm == S_WAIT && wb_take) |=> (msg_valid && msg_kind == MK_DATA));
   // R5: invalidation state always has a target
   assert_inv_has_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm == S_INV) |-> pick_any);
endmodule

// File: tb/tb_dir_home.sv
`timescale 1ns/1ps
module tb_dir_home;
   localparam int NPROC = 4;
   localparam int NBLK  = 8;
   localparam int DW    = 16;
   localparam int PW    = $clog2(NPROC);
   localparam int AW    = $clog2(NBLK);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [PW-1:0] req_pid = '0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ready;
   logic          wb_valid = 1'b0;
   logic [PW-1:0] wb_pid = '0;
   logic [AW-1:0] wb_addr = '0;
   logic [DW-1:0] wb_data = '0;
   logic          wb_ready;
   logic          msg_valid, msg_ready = 1'b1;
   logic [1:0]    msg_kind;
   logic [PW-1:0] msg_pid;
   logic [AW-1:0] msg_addr;
   logic [DW-1:0] msg_data;

   always #2.5 clk = ~clk;

   dir_home #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_pid(req_pid), .req_addr(req_addr),
      .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_pid(wb_pid),
      .wb_addr(wb_addr), .wb_data(wb_data),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
      .msg_pid(msg_pid), .msg_addr(msg_addr), .msg_data(msg_data)
   );

   typedef struct {
      int    kind;
      int    pid;
      int    addr;
      int    data;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   fails  = 0;
   int   cycles = 0;
   bit   done   = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic expect_msg(input int k, input int p, input int a,
                             input int d, input string tag);
      exp_t e;
      e.kind = k; e.pid = p; e.addr = a; e.data = d; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compares each handed-off message with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && msg_valid && msg_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "unexpected", "msg_kind", int'(msg_kind), -1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(int'(msg_kind) == e.kind, e.tag, "kind", int'(msg_kind), e.kind);
            chk(int'(msg_pid) == e.pid, e.tag, "pid", int'(msg_pid), e.pid);
            chk(int'(msg_addr) == e.addr, e.tag, "addr", int'(msg_addr), e.addr);
            chk(int'(msg_data) == e.data, e.tag, "data", int'(msg_data), e.data);
         end
      end
   end

   task automatic send_req(input bit w, input int p, input int a);
      @(negedge clk);
      req_valid = 1'b1; req_write = w;
      req_pid = PW'(p); req_addr = AW'(a);
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic send_wb(input int p, input int a, input int d);
      @(negedge clk);
      wb_valid = 1'b1; wb_pid = PW'(p); wb_addr = AW'(a); wb_data = DW'(d);
      #1;
      while (!wb_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      wb_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset
      chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
      chk(msg_valid == 1'b0, "R1", "msg_valid", int'(msg_valid), 0);
      chk(wb_ready == 1'b1, "R1", "wb_ready", int'(wb_ready), 1);

      // R2: read miss to Uncached, zero data after reset (R1)
      expect_msg(3, 1, 2, 0, "R2");
      send_req(1'b0, 1, 2); drain();
      // R3: read miss to Shared
      expect_msg(3, 3, 2, 0, "R3");
      send_req(1'b0, 3, 2); drain();
      // R5: write miss to Shared {1,3}
      expect_msg(0, 1, 2, 0, "R5");
      expect_msg(0, 3, 2, 0, "R5");
      expect_msg(3, 0, 2, 0, "R5");
      send_req(1'b1, 0, 2); drain();
      // R6: read miss to Exclusive owned by 0
      expect_msg(1, 0, 2, 0, "R6");
      expect_msg(3, 2, 2, 16'h1234, "R6");
      send_req(1'b0, 2, 2);
      #1 chk(req_ready == 1'b0, "R10", "req_ready busy", int'(req_ready), 0);
      send_wb(0, 2, 16'h1234); drain();
      // R6: block is now Shared {0,2}; a write miss invalidates both
      expect_msg(0, 0, 2, 0, "R6");
      expect_msg(0, 2, 2, 0, "R6");
      expect_msg(3, 1, 2, 16'h1234, "R6");
      send_req(1'b1, 1, 2); drain();
      // R7: write miss to Exclusive owned by 1
      expect_msg(2, 1, 2, 0, "R7");
      expect_msg(3, 3, 2, 16'hBEEF, "R7");
      send_req(1'b1, 3, 2);
      send_wb(1, 2, 16'hBEEF); drain();
      // R8: eviction by owner 3, then read sees new data without a fetch
      send_wb(3, 2, 16'h5555);
      expect_msg(3, 0, 2, 16'h5555, "R8");
      send_req(1'b0, 0, 2); drain();
      // R8: presence vector was emptied: only 0 is invalidated
      expect_msg(0, 0, 2, 0, "R8");
      expect_msg(3, 2, 2, 16'h5555, "R8");
      send_req(1'b1, 2, 2); drain();
      // R4: write miss to Uncached, no invalidation
      expect_msg(3, 1, 5, 0, "R4");
      send_req(1'b1, 1, 5); drain();
      // R4/R12: single owner 1 is fetched
      expect_msg(1, 1, 5, 0, "R4");
      expect_msg(3, 0, 5, 16'h0A0A, "R4");
      send_req(1'b0, 0, 5);
      send_wb(1, 5, 16'h0A0A); drain();
      // R5: requester 0 already present; only 1 invalidated
      expect_msg(0, 1, 5, 0, "R5");
      expect_msg(3, 0, 5, 16'h0A0A, "R5");
      send_req(1'b1, 0, 5); drain();
      // R9: write-back to Uncached block ignored
      send_wb(3, 6, 16'h7777);
      expect_msg(3, 0, 6, 0, "R9");
      send_req(1'b0, 0, 6); drain();
      // R9: write-back by non-owner of Exclusive block ignored
      send_wb(2, 5, 16'hDEAD);
      expect_msg(1, 0, 5, 0, "R9");
      expect_msg(3, 1, 5, 16'h0B0B, "R9");
      send_req(1'b0, 1, 5);
      send_wb(0, 5, 16'h0B0B); drain();

      // R11: reply held under back-pressure
      msg_ready = 1'b0;
      send_req(1'b0, 1, 6);
      repeat (4) @(negedge clk);
      chk(msg_valid == 1'b1, "R11", "msg_valid held", int'(msg_valid), 1);
      chk(msg_kind == 2'd3, "R11", "msg_kind held", int'(msg_kind), 3);
      chk(msg_pid == PW'(1), "R11", "msg_pid held", int'(msg_pid), 1);
      expect_msg(3, 1, 6, 0, "R11");
      @(posedge clk); #1 msg_ready = 1'b1;
      drain();

      // R10: write-back and request together; write-back goes first
      expect_msg(3, 1, 3, 0, "R10");
      send_req(1'b1, 1, 3); drain();
      @(negedge clk);
      wb_valid = 1'b1; wb_pid = PW'(1); wb_addr = AW'(3); wb_data = DW'(16'h3333);
      req_valid = 1'b1; req_write = 1'b0; req_pid = PW'(2); req_addr = AW'(3);
      #1 chk(req_ready == 1'b0, "R10", "req_ready with wb", int'(req_ready), 0);
      expect_msg(3, 2, 3, 16'h3333, "R10");
      @(negedge clk);
      wb_valid = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      drain();

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R10", "scoreboard empty", exp_q.size(), 0);
      finish_run();
   end
endmodule